// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous 64K x 16 Static RAM

This block lets synchronous logic use an external asynchronous static RAM of 65,536 sixteen-bit words with two byte lanes. The user side takes one request at a time over a valid/ready handshake. A request carries a word address, a write flag, write data and one enable bit per byte lane. Reads return their data with a single-cycle valid pulse. The memory side has registered, active-low controls: chip select, output enable, write strobe and one select per byte lane. The shared data bus is split into an outgoing word, an incoming word and a drive enable, and the pad ring closes the tri-state.

The memory has no clock, so every timing minimum becomes a count of clock cycles. These counts are derived when the block is elaborated from nanosecond parameters and the clock period, always rounding up. Every write is ended by the rising edge of the write strobe. Address, lane selects and data are held steady from one cycle before the strobe falls until at least one cycle after it rises. After every read, the bus rests with nothing driving it before the controller can drive it again.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and on leaving it, chip select, output enable, write strobe and both lane selects are high, the drive enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. For any request that starts a memory cycle, `req_ready` is low in the next cycle and stays low until that cycle, including its recovery, has finished.
- R3: A read holds chip select and output enable low with the write strobe high for exactly ceil(RD_ACCESS_NS/CLK_NS) cycles (at least one). Data is captured at the edge that ends this window, and `rsp_valid` is high for exactly the one cycle that follows.
- R4: `req_be[1]` selects the upper byte (bits 15:8) and `req_be[0]` the lower byte (bits 7:0). While chip select is low, `mem_lane_n[i]` is low exactly when `req_be[i]` of the request being served is 1. Read data bytes whose enable is 0 are returned as zero, and a read with both enables 0 returns zero.
- R5: The write strobe is low only while chip select is low and at least one lane select is low. Each strobe lasts exactly max(ceil(WE_PULSE_NS/CLK_NS), ceil(DATA_SETUP_NS/CLK_NS)) cycles.
- R6: A write drives data with chip select low for exactly one cycle before the strobe falls. Address, lanes and data stay steady while the strobe is low and for at least one cycle after it rises. Chip select stays low for max(strobe cycles + 2, ceil(WR_CYCLE_NS/CLK_NS)) cycles in total.
- R7: A write request with both byte enables 0 is accepted without any chip select or strobe activity. The controller is ready again in the next cycle, and memory contents are unchanged.
- R8: The controller never drives the bus while output enable is low, and it never drives in the cycle right after output enable was low. After each read, exactly TURN_CYC cycles follow with chip select high and `req_ready` low.
- R9: A write followed by a read of the same address returns the new bytes in the written lanes and the earlier bytes in the other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte-lane enables, bit i = byte i |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | DATA_W | Read data, disabled bytes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_lane_n | output | DATA_W/8 | Byte-lane selects, active low, bit 1 upper |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_in | input | DATA_W | Data received from the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |

## Verification
The bench sets the clock to 8 ns, the read access time to 20 ns, the strobe width to 12 ns, the data setup to 9 ns, the write cycle to 48 ns and the turnaround to two cycles. With these values the read window is three cycles and the strobe is two cycles long, and the write recovery is stretched to three cycles by the write-cycle minimum rather than by the one-cycle floor. A two-cycle turnaround also makes an off-by-one in the gap after a read visible. The bench's memory model returns garbage until the address has been steady for the full access time. It also measures the strobe width and the data setup in real time against the nanosecond figures, so an error in the rounding shows up as corrupted data or as a timing miss.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD     = 3'd1,
    ST_TURN   = 3'd2,
    ST_WSET   = 3'd3,
    ST_WPULSE = 3'd4,
    ST_WHOLD  = 3'd5
  } ctl_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int cycles_for(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return imax(c, 1);
  endfunction

  // strobe must satisfy both its own width and the data setup
  function automatic int strobe_cycles(input int pulse_ns, input int setup_ns, input int clk_ns);
    return imax(cycles_for(pulse_ns, clk_ns), cycles_for(setup_ns, clk_ns));
  endfunction

  // cycles after the strobe rises: at least one, more if the write cycle needs it
  function automatic int hold_cycles(input int wc_ns, input int clk_ns, input int strobe);
    return imax(1, cycles_for(wc_ns, clk_ns) - 1 - strobe);
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int RD_CYC   = 2,
  parameter int WE_CYC   = 1,
  parameter int HOLD_CYC = 1,
  parameter int TURN_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_be,
  output logic             req_ready,
  output logic             ev_accept,
  output logic             ev_rd_last,
  output ctl_state_t       state_d
);

  localparam int MAXC = imax(imax(RD_CYC, WE_CYC), imax(HOLD_CYC, TURN_CYC));
  localparam int CW   = $clog2(MAXC + 1);

  ctl_state_t    state_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_zero;

  assign cnt_zero   = (cnt_q == '0);
  assign req_ready  = (state_q == ST_IDLE);
  assign ev_accept  = req_valid && req_ready;
  assign ev_rd_last = (state_q == ST_RD) && cnt_zero;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_zero ? '0 : cnt_q - 1'b1;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (!req_write) begin
            state_d = ST_RD;
            cnt_d   = CW'(RD_CYC - 1);
          end else if (|req_be) begin
            state_d = ST_WSET;
            cnt_d   = '0;
          end
        end
      end
      ST_RD: begin
        if (cnt_zero) begin
          state_d = ST_TURN;
          cnt_d   = CW'(TURN_CYC - 1);
        end
      end
      ST_TURN:   if (cnt_zero) state_d = ST_IDLE;
      ST_WSET: begin
        state_d = ST_WPULSE;
        cnt_d   = CW'(WE_CYC - 1);
      end
      ST_WPULSE: begin
        if (cnt_zero) begin
          state_d = ST_WHOLD;
          cnt_d   = CW'(HOLD_CYC - 1);
        end
      end
      ST_WHOLD:  if (cnt_zero) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // a request that opens a memory cycle closes the handshake next cycle
  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && (!req_write || (|req_be)) |=> !req_ready);

  // after the last read cycle the controller stays busy for the turnaround
  assert_turn_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_last |=> !req_ready);

endmodule

// File: rtl/sram_ctrl_pins.sv
`timescale 1ns/1ps
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int WE_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_accept,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  ctl_state_t        state_d,
  output logic [LANES-1:0]  be_q,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_lane_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);

  localparam int RW = $clog2(WE_CYC + 2);

  logic             busy_d, drive_d;
  logic [LANES-1:0] be_sel, lane_on_d;

  assign busy_d  = (state_d == ST_RD) || (state_d == ST_WSET) ||
                   (state_d == ST_WPULSE) || (state_d == ST_WHOLD);
  assign drive_d = (state_d == ST_WSET) || (state_d == ST_WPULSE) ||
                   (state_d == ST_WHOLD);
  assign be_sel  = ev_accept ? req_be : be_q;

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    assign lane_on_d[gl] = busy_d && be_sel[gl];
  end

  // every pin comes straight from a flop: no decode glitches reach the memory
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_q       <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_ce_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_lane_n <= '1;
      mem_dq_oe  <= 1'b0;
    end else begin
      if (ev_accept) begin
        be_q       <= req_be;
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      mem_ce_n   <= !busy_d;
      mem_oe_n   <= (state_d != ST_RD);
      mem_we_n   <= (state_d != ST_WPULSE);
      mem_lane_n <= ~lane_on_d;
      mem_dq_oe  <= drive_d;
    end
  end

  // run length of the write strobe, observed by the width check only
  logic [RW-1:0] we_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_run <= '0;
    else if (!mem_we_n) we_run <= we_run + 1'b1;
    else                we_run <= '0;
  end

  assert_reset_pins_R1: assert property (@(posedge clk)
    !rst_n |=> mem_ce_n && mem_oe_n && mem_we_n && (mem_lane_n == '1) && !mem_dq_oe);

  assert_lanes_follow_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> (mem_lane_n == ~be_q));

  assert_strobe_qualified_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n && (mem_lane_n != '1) && mem_dq_oe);

  assert_strobe_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == RW'(WE_CYC)));

  assert_setup_before_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(mem_dq_oe) && !$past(mem_ce_n));

  assert_hold_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe && !mem_ce_n);

  assert_steady_under_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> $stable(mem_addr) && $stable(mem_dq_out) && $stable(mem_lane_n));

  assert_empty_write_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept && req_write && !(|req_be) |=> mem_ce_n && mem_we_n);

  assert_no_drive_in_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_gap_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |=> !mem_dq_oe);

endmodule

// File: rtl/sram_ctrl_rdcap.sv
`timescale 1ns/1ps
module sram_ctrl_rdcap #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int RD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_rd_last,
  input  logic [LANES-1:0]  be_q,
  input  logic [DATA_W-1:0] mem_dq_in,
  input  logic              mem_oe_n,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int RW = $clog2(RD_CYC + 2);

  logic [DATA_W-1:0] cap_d;

  for (genvar gl = 0; gl < LANES; gl++) begin : g_mask
    assign cap_d[gl*8 +: 8] = be_q[gl] ? mem_dq_in[gl*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= ev_rd_last;
      if (ev_rd_last) rsp_rdata <= cap_d;
    end
  end

  // length of the output-enable window, observed by the checks only
  logic [RW-1:0] oe_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         oe_run <= '0;
    else if (!mem_oe_n) oe_run <= oe_run + 1'b1;
    else                oe_run <= '0;
  end

  assert_read_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_run == RW'(RD_CYC)) && rsp_valid);

  assert_rsp_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int CLK_NS        = 8,
  parameter int RD_ACCESS_NS  = 10,
  parameter int WE_PULSE_NS   = 8,
  parameter int DATA_SETUP_NS = 6,
  parameter int WR_CYCLE_NS   = 10,
  parameter int TURN_CYC      = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_be,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_ce_n,
  output logic                  mem_oe_n,
  output logic                  mem_we_n,
  output logic [DATA_W/8-1:0]   mem_lane_n,
  output logic [DATA_W-1:0]     mem_dq_out,
  input  logic [DATA_W-1:0]     mem_dq_in,
  output logic                  mem_dq_oe
);

  localparam int LANES    = DATA_W / 8;
  localparam int RD_CYC   = cycles_for(RD_ACCESS_NS, CLK_NS);
  localparam int WE_CYC   = strobe_cycles(WE_PULSE_NS, DATA_SETUP_NS, CLK_NS);
  localparam int HOLD_CYC = hold_cycles(WR_CYCLE_NS, CLK_NS, WE_CYC);
  localparam int TURN_N   = imax(TURN_CYC, 1);

  logic             ev_accept, ev_rd_last;
  ctl_state_t       state_d;
  logic [LANES-1:0] be_q;

  sram_ctrl_fsm #(
    .LANES(LANES), .RD_CYC(RD_CYC), .WE_CYC(WE_CYC),
    .HOLD_CYC(HOLD_CYC), .TURN_CYC(TURN_N)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_be(req_be),
    .req_ready(req_ready), .ev_accept(ev_accept), .ev_rd_last(ev_rd_last),
    .state_d(state_d)
  );

  sram_ctrl_pins #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES), .WE_CYC(WE_CYC)
  ) u_pins (
    .clk(clk), .rst_n(rst_n),
    .ev_accept(ev_accept), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .state_d(state_d), .be_q(be_q),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe)
  );

  sram_ctrl_rdcap #(
    .DATA_W(DATA_W), .LANES(LANES), .RD_CYC(RD_CYC)
  ) u_rdcap (
    .clk(clk), .rst_n(rst_n),
    .ev_rd_last(ev_rd_last), .be_q(be_q), .mem_dq_in(mem_dq_in),
    .mem_oe_n(mem_oe_n), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> req_ready && !rsp_valid);

endmodule

// File: tb/sim_sram_ctrl.sv
`timescale 1ns/100ps
module sim_sram_ctrl;

  localparam int CLK_NS = 8;
  localparam int RD_NS  = 20;
  localparam int WEP_NS = 12;
  localparam int SU_NS  = 9;
  localparam int WC_NS  = 48;
  localparam int TURN   = 2;

  // expectations worked out independently from the requirement text
  localparam int EXP_RD   = (RD_NS + CLK_NS - 1) / CLK_NS;                 // 3
  localparam int EXP_WE_A = (WEP_NS + CLK_NS - 1) / CLK_NS;
  localparam int EXP_WE_B = (SU_NS + CLK_NS - 1) / CLK_NS;
  localparam int EXP_WE   = (EXP_WE_A > EXP_WE_B) ? EXP_WE_A : EXP_WE_B;  // 2
  localparam int EXP_WC   = (WC_NS + CLK_NS - 1) / CLK_NS;
  localparam int EXP_CE   = (EXP_WC > EXP_WE + 2) ? EXP_WC : EXP_WE + 2;  // 6

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata, mem_addr, mem_dq_out;
  logic [15:0] mem_dq_in = 16'hFFFF;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_lane_n;

  int n_chk = 0;
  int n_bad = 0;
  bit clash = 1'b0;

  always #4 clk = ~clk;

  sram_ctrl #(
    .CLK_NS(CLK_NS), .RD_ACCESS_NS(RD_NS), .WE_PULSE_NS(WEP_NS),
    .DATA_SETUP_NS(SU_NS), .WR_CYCLE_NS(WC_NS), .TURN_CYC(TURN)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory model and reference copy ----------------
  logic [15:0] cells [int];
  logic [15:0] refm  [int];
  realtime t_chg = 0, t_wef = 0, t_dq = 0;

  function automatic logic [15:0] peek_cell(input int a);
    return cells.exists(a) ? cells[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] peek_ref(input int a);
    return refm.exists(a) ? refm[a] : 16'h0000;
  endfunction

  always @(mem_addr or mem_ce_n or mem_oe_n or mem_we_n or mem_lane_n) t_chg = $realtime;
  always @(mem_dq_out or mem_dq_oe) t_dq = $realtime;
  always @(negedge mem_we_n) t_wef = $realtime;

  initial begin
    #0.5;
    forever begin
      logic [15:0] v;
      if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
        v = ($realtime - t_chg >= RD_NS) ? peek_cell(int'(mem_addr)) : 16'hDEAD;
        if (mem_lane_n[0]) v[7:0]  = 8'hFF;
        if (mem_lane_n[1]) v[15:8] = 8'hFF;
        mem_dq_in = v;
      end else begin
        mem_dq_in = 16'hFFFF;
      end
      #1;
    end
  end

  always @(posedge mem_we_n) begin
    if (rst_n && !mem_ce_n) begin
      logic [15:0] w;
      check("R5", "strobe width in ns >= minimum", ($realtime - t_wef) >= WEP_NS, 1);
      check("R6", "data setup in ns before strobe end", ($realtime - t_dq) >= SU_NS, 1);
      check("R6", "bus driven at strobe end", mem_dq_oe, 1);
      w = peek_cell(int'(mem_addr));
      if (!mem_lane_n[0]) w[7:0]  = mem_dq_out[7:0];
      if (!mem_lane_n[1]) w[15:8] = mem_dq_out[15:8];
      cells[int'(mem_addr)] = w;
    end
  end

  always @(negedge clk)
    if (rst_n && mem_dq_oe && !mem_ce_n && !mem_oe_n && mem_we_n) clash = 1'b1;

  // ---------------- scenario tasks ----------------
  task automatic issue(input logic wr, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R1", "ce_n after reset", mem_ce_n, 1);
    check("R1", "oe_n after reset", mem_oe_n, 1);
    check("R1", "we_n after reset", mem_we_n, 1);
    check("R1", "lane_n after reset", mem_lane_n, 2'b11);
    check("R1", "dq_oe after reset", mem_dq_oe, 0);
    check("R1", "ready after reset", req_ready, 1);
    check("R1", "rsp_valid after reset", rsp_valid, 0);
  endtask

  task automatic t_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be);
    int ce_c = 0, we_c = 0, pre = 0, post = 0, guard = 0;
    bit lanes_ok = 1'b1;
    bit first_busy;
    logic [15:0] r;
    issue(1'b1, a, d, be);
    first_busy = !req_ready;
    while (!req_ready && guard < 200) begin
      guard++;
      if (!mem_ce_n) ce_c++;
      if (!mem_we_n) we_c++;
      else if (!mem_ce_n) begin
        if (we_c == 0) pre++; else post++;
      end
      if (!mem_ce_n && mem_lane_n !== ~be) lanes_ok = 1'b0;
      @(negedge clk);
    end
    if (be == 2'b00) begin
      check("R7", "empty write: chip select cycles", ce_c, 0);
      check("R7", "empty write: strobe cycles", we_c, 0);
      check("R7", "empty write: ready next cycle", first_busy, 0);
    end else begin
      check("R2", "ready low after write accept", first_busy, 1);
      check("R5", "strobe low cycles", we_c, EXP_WE);
      check("R6", "chip select low cycles", ce_c, EXP_CE);
      check("R6", "setup cycles before strobe", pre, 1);
      check("R6", "hold cycles after strobe", post, EXP_CE - 1 - EXP_WE);
      check("R4", "write lane selects", lanes_ok, 1);
      r = peek_ref(int'(a));
      if (be[0]) r[7:0]  = d[7:0];
      if (be[1]) r[15:8] = d[15:8];
      refm[int'(a)] = r;
    end
  endtask

  task automatic t_read(input logic [15:0] a, input logic [1:0] be, input string req);
    int oe_c = 0, turn = 0, rsp_n = 0, rsp_at = 0, idx = 0, guard = 0;
    bit lanes_ok = 1'b1;
    bit first_busy;
    logic [15:0] got = 16'h0, exp;
    issue(1'b0, a, 16'h0, be);
    first_busy = !req_ready;
    while (!req_ready && guard < 200) begin
      guard++; idx++;
      if (!mem_oe_n) oe_c++;
      if (rsp_valid) begin rsp_n++; rsp_at = idx; got = rsp_rdata; end
      if (mem_ce_n) turn++;
      if (!mem_ce_n && mem_lane_n !== ~be) lanes_ok = 1'b0;
      @(negedge clk);
    end
    exp = peek_ref(int'(a));
    if (!be[0]) exp[7:0]  = 8'h00;
    if (!be[1]) exp[15:8] = 8'h00;
    check("R2", "ready low after read accept", first_busy, 1);
    check("R3", "output enable window cycles", oe_c, EXP_RD);
    check("R3", "response pulses", rsp_n, 1);
    check("R3", "response cycle index", rsp_at, EXP_RD + 1);
    check("R8", "turnaround cycles", turn, TURN);
    check("R4", "read lane selects", lanes_ok, 1);
    check(req, "read data", got, exp);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();

    t_write(16'h0000, 16'h1234, 2'b11);
    t_read (16'h0000, 2'b11, "R9");
    t_write(16'hFFFF, 16'hA5C3, 2'b11);
    t_read (16'hFFFF, 2'b11, "R9");
    t_read (16'h4321, 2'b11, "R3");            // never written: zero

    t_write(16'h1234, 16'hBEEF, 2'b11);
    t_write(16'h1234, 16'h5511, 2'b10);        // upper lane only
    t_read (16'h1234, 2'b11, "R9");            // 55EF
    t_read (16'h1234, 2'b01, "R4");            // 00EF
    t_read (16'h1234, 2'b10, "R4");            // 5500
    t_read (16'h1234, 2'b00, "R4");            // 0000

    t_write(16'h1234, 16'h0000, 2'b00);        // no lanes: nothing happens
    t_read (16'h1234, 2'b11, "R7");            // still 55EF

    t_write(16'h00FF, 16'h3C00, 2'b01);        // lower lane only
    t_read (16'h00FF, 2'b11, "R9");

    check("R8", "no bus contention seen", clash, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * CLK_NS);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule